// File: doc/BRIEF.md
# Two-Requester Shared Bus Arbiter with Switch Gap

This block lets two serial-memory controllers take turns on one external bus. Each controller asks for the bus by raising its request line and may drive the shared data, strobe and clock wires only while its acknowledge is high. Dropping the request hands the bus back. The arbiter then holds both acknowledges low for a programmable number of cycles before it grants the bus again. This gives the pads and the memory device time to settle between owners. A select output steers the external mux that picks which controller's data, strobe and clock lines reach the pins. Chip selects bypass the arbiter completely.

Sharing is turned on by a single enable input. While the enable is low the two controllers use separate buses. In that mode the arbiter grants nothing and ignores all requests. The gap length comes from an 8-bit configuration input. The value is captured at the moment of each release, so changing the input in the middle of a gap does not affect the gap already running. Ownership alternates: after a release, the other controller wins if it is waiting. The very first tie goes to controller 0.

Top module: `bus_share_arbiter`

## Requirements
- R1: After reset both acknowledge bits are 0 and `bus_sel` is 0.
- R2: While `mux_en` is 0, requests are ignored. `ack` stays 2'b00 regardless of `req`.
- R3: From idle with `mux_en` = 1, a single request sampled at a clock edge raises the matching acknowledge bit (bit 0 for controller 0, bit 1 for controller 1) after that same edge.
- R4: When both requests appear together at the first arbitration after reset, controller 0 receives the grant.
- R5: The acknowledge stays high for as long as its owner holds its request high. It drops after the first clock edge at which the owner's request is sampled low.
- R6: After a release, both acknowledges stay low for exactly `gap_cycles` + 1 clock cycles before the next grant, when a request is pending. The value of `gap_cycles` is captured at the release.
- R7: After a release, the other controller is granted if it is requesting, even when the releasing controller requests again.
- R8: When the releasing controller is the only requester, it is granted again only after the same gap as in R6.
- R9: At most one acknowledge bit is high in any cycle.
- R10: `bus_sel` equals the owner's index (0 or 1) whenever an acknowledge is high. It changes only in a cycle that follows a cycle with both acknowledges low.
- R11: Clearing `mux_en` while the bus is granted drops the acknowledge after the next clock edge and returns the arbiter to idle. A later enable grants a pending request after one edge, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_en | input | 1 | Enables time-sharing and arbitration |
| gap_cycles | input | 8 | Switch gap minus one, in clock cycles |
| req | input | 2 | Bus requests, bit i from controller i |
| ack | output | 2 | Bus grants, bit i to controller i |
| bus_sel | output | 1 | Shared bus mux select: index of the current or last owner |

## Verification
A wrong state register shows at the ports quickly. Either an acknowledge stays high one cycle after its request is seen low, or two acknowledges are high together, or `bus_sel` disagrees with the granted bit. All of these are visible within a single cycle. A wrong gap counter value or a wrong priority bit only shows at the next hand-over, as a low-acknowledge window of the wrong length or a grant to the wrong controller. For that reason the bench measures every gap length it programs and alternates owners on each of them.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned NUM_REQ = 2;
  localparam int unsigned IDX_W   = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OWN  = 2'd1,
    ST_GAP  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
(
  input  logic [NUM_REQ-1:0] req,
  input  logic [IDX_W-1:0]   pref,
  output logic               any,
  output logic [IDX_W-1:0]   win
);
  always_comb begin
    any = |req;
    if (req[0] && req[1]) win = pref;
    else if (req[1])      win = 1'b1;
    else                  win = 1'b0;
  end
endmodule

// File: rtl/arb_gap_timer.sv
module arb_gap_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (dec && (cnt_q != '0));
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  a_r6_load_dec_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && dec));
  a_r6_no_dec_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !zero);
  a_r6_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/bus_share_arbiter.sv
module bus_share_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned GAP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mux_en,
  input  logic [GAP_W-1:0]   gap_cycles,
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] ack,
  output logic               bus_sel
);
  arb_state_e         state_q, state_d;
  logic [NUM_REQ-1:0] ack_q, ack_d;
  logic [IDX_W-1:0]   sel_q, sel_d;
  logic [IDX_W-1:0]   pref_q, pref_d;
  logic               pick_any;
  logic [IDX_W-1:0]   pick_win;
  logic               tmr_load, tmr_dec, tmr_zero;

  arb_pick u_pick (
    .req  (req),
    .pref (pref_q),
    .any  (pick_any),
    .win  (pick_win)
  );

  arb_gap_timer #(.CNT_W(GAP_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (gap_cycles),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    ack_d    = ack_q;
    sel_d    = sel_q;
    pref_d   = pref_q;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (mux_en && pick_any) begin
          state_d = ST_OWN;
          ack_d   = pick_win ? 2'b10 : 2'b01;
          sel_d   = pick_win;
          pref_d  = ~pick_win;
        end
      end
      ST_OWN: begin
        if (!mux_en) begin
          state_d = ST_IDLE;
          ack_d   = '0;
        end else if (!req[sel_q]) begin
          state_d  = ST_GAP;
          ack_d    = '0;
          tmr_load = 1'b1;
        end
      end
      ST_GAP: begin
        if (!mux_en) begin
          state_d = ST_IDLE;
        end else if (!tmr_zero) begin
          tmr_dec = 1'b1;
        end else if (pick_any) begin
          state_d = ST_OWN;
          ack_d   = pick_win ? 2'b10 : 2'b01;
          sel_d   = pick_win;
          pref_d  = ~pick_win;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        ack_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_q   <= '0;
      sel_q   <= '0;
      pref_q  <= '0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      sel_q   <= sel_d;
      pref_q  <= pref_d;
    end
  end

  assign ack     = ack_q;
  assign bus_sel = sel_q;

  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));
  a_r10_sel_matches_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |-> (ack[bus_sel] == 1'b1));
  a_r10_sel_moves_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_sel) |-> ($past(ack) == '0));
  a_r2_off_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !mux_en |=> (ack == '0));
  a_r5_drop_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[0] && !req[0]) |=> !ack[0]);
  a_r5_hold_while_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[1] && req[1] && mux_en) |=> ack[1]);
  a_r6_no_grant_from_gap_early: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP && !tmr_zero) |=> (ack == '0));
endmodule

// File: tb/bus_share_arbiter_bench.sv
module bus_share_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mux_en;
  logic [7:0] gap_cycles;
  logic [1:0] req;
  logic [1:0] ack;
  logic       bus_sel;
  int         n_checks = 0;
  int         n_errors = 0;

  always #5 clk = ~clk;

  bus_share_arbiter u_bus_share_arbiter (
    .clk(clk), .rst_n(rst_n), .mux_en(mux_en), .gap_cycles(gap_cycles),
    .req(req), .ack(ack), .bus_sel(bus_sel)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Counts negedges with no grant after a release; returns the count.
  task automatic measure_gap(output int cnt);
    cnt = 0;
    step();
    while (ack == 2'b00 && cnt < 400) begin
      cnt++;
      step();
    end
  endtask

  initial begin
    #(200000 * 10);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    int gap;
    int owner;
    int dvals [10];
    dvals = '{0, 1, 2, 3, 4, 5, 6, 7, 31, 255};
    rst_n = 1'b0; mux_en = 1'b0; gap_cycles = 8'd0; req = 2'b00;
    step(); step();
    rst_n = 1'b1;
    step();
    check("R1 ack after reset", ack, 0);
    check("R1 sel after reset", bus_sel, 0);

    // R2: disabled, requests ignored
    req = 2'b11;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R2 ack while disabled", ack, 0);
    end

    // R4/R3: enable with both requesting; controller 0 first
    mux_en = 1'b1;
    step();
    check("R4 first tie to controller 0", ack, 1);
    check("R10 sel follows owner", bus_sel, 0);
    for (int i = 0; i < 5; i++) begin
      step();
      check("R5 ack held while requested", ack, 1);
    end

    // R6/R7: gap sweep with alternating owners, both requesting
    owner = 0;
    foreach (dvals[k]) begin
      gap_cycles = dvals[k][7:0];
      req[owner] = 1'b0;
      measure_gap(gap);
      check("R6 gap length", gap, dvals[k] + 1);
      check("R7 other controller wins", ack, 1 << (1 - owner));
      check("R10 sel equals new owner", bus_sel, 1 - owner);
      req[owner] = 1'b1;
      owner = 1 - owner;
    end

    // R8: sole requester re-granted after the same gap
    req[1 - owner] = 1'b0;
    step(); step();
    check("R8 setup owner holds", ack, 1 << owner);
    gap_cycles = 8'd3;
    req[owner] = 1'b0;
    step();
    check("R5 ack drops after release", ack, 0);
    req[owner] = 1'b1;
    gap = 1;
    step();
    while (ack == 2'b00 && gap < 400) begin
      gap++;
      step();
    end
    check("R8 sole requester gap", gap, 4);
    check("R8 sole requester regranted", ack, 1 << owner);

    // R11: clearing enable while granted
    mux_en = 1'b0;
    step();
    check("R11 ack drops on disable", ack, 0);
    step();
    check("R11 stays off", ack, 0);
    gap_cycles = 8'd200;
    mux_en = 1'b1;
    step();
    check("R11 regrant with no gap", ack, 1 << owner);

    // R3: single request from idle, controller 1
    req = 2'b00;
    gap_cycles = 8'd2;
    for (int i = 0; i < 6; i++) step();
    check("R3 idle with no requests", ack, 0);
    req = 2'b10;
    step();
    check("R3 single request granted next edge", ack, 2);
    check("R10 sel for controller 1", bus_sel, 1);
    req = 2'b00;
    for (int i = 0; i < 6; i++) step();
    req = 2'b01;
    step();
    check("R3 single request controller 0", ack, 1);
    check("R10 sel for controller 0", bus_sel, 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule